// File: doc/BRIEF.md
# Strap-Configured Multi-Address I2C Target Decoder

This block is the address-matching stage of an I2C target that answers to three 7-bit addresses: one primary address chosen by a 3-bit strap index, and two alias addresses held in software-written registers. When the power-down input is released, the block waits a settle interval of one millisecond, counted in clock cycles from the clock frequency parameter. It then captures the strap index and turns it into the primary address. Until that capture, every address is refused.

Each completed address byte is compared with the primary address and with both aliases. The result is registered and appears one cycle later as a match pulse, a 2-bit register-page select, a forced-page flag and the read/write bit. A hit on an alias steers the access straight to that receive port's register page and does not use the paging register. The shared registers stay reachable through every address, because the page select only affects the paged region. A hit on the primary address takes its page from the 2-bit paging register.

Top module: `strap_addr_decoder`

## Requirements
- R1: With `pwrEnable` high, the primary address is captured from `strapIdx` on exactly the SETTLE_CYCLES-th rising edge, where SETTLE_CYCLES = CLK_HZ/1000. Later changes of `strapIdx` have no effect until the next power-up.
- R2: Any address byte whose `addrValid` edge falls before that capture, including the capture edge itself, gives `matchPulse` = 0.
- R3: Strap index i (0 to 6) selects primary address 0x30 + 2*i, and index 7 selects 0x3D.
- R4: The address is `addrByte[7:1]` and the read/write bit is `addrByte[0]` (1 = read). All outputs change on the clock edge that samples `addrValid` high, and `rwBit` holds the last captured value.
- R5: An alias register matches on its bits [7:1], and its bit 0 is ignored. An alias whose bits [7:1] are all zero is disabled and never matches.
- R6: A hit on alias 0 gives `pageSel` = 2'b01, and a hit on alias 1 gives `pageSel` = 2'b10. Both set `pageForced` = 1.
- R7: A hit on the primary address gives `pageForced` = 0. A write gives `pageSel` = `pageCtl`, and a read gives only the lowest set bit of `pageCtl` (2'b11 gives 2'b01, 2'b00 gives 2'b00).
- R8: When more than one address matches, the primary wins over alias 0, and alias 0 wins over alias 1.
- R9: With no hit, `matchPulse`, `pageSel` and `pageForced` are all zero. `matchPulse` is high only in the cycle after an `addrValid` cycle.
- R10: When `pwrEnable` goes low, matching stops on the next edge. Raising it again starts a new settle interval and captures the strap again.
- R11: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrEnable | input | 1 | High releases power-down |
| strapIdx | input | 3 | Strap index from the divider converter |
| addrValid | input | 1 | One-cycle strobe: address byte complete |
| addrByte | input | 8 | Received address byte, bit 0 = read/write |
| alias0Reg | input | 8 | Port 0 alias register value |
| alias1Reg | input | 8 | Port 1 alias register value |
| pageCtl | input | 2 | Paging register, bit n selects port n |
| matchPulse | output | 1 | Address acknowledged |
| pageSel | output | 2 | Register page select |
| pageForced | output | 1 | Page set by an alias hit |
| rwBit | output | 1 | Captured read/write bit |

## Verification
The hardest case to reach is the exact edge on which the strap is captured. The address strobe then meets the capture in the same cycle and must still be refused, while one cycle later it must be accepted. The bench lowers the settle count through CLK_HZ. It times an address strobe onto the capture edge and another onto the edge after it. It also repeats the power-down and power-up cycle for every strap index, so that each captured address can be probed through matching.

// File: rtl/strap_addr_pkg.sv
package strap_addr_pkg;

  typedef struct packed {
    logic latchStrap;
    logic decodeEn;
  } ctlStrobes_t;

  // index 0..6 -> 0x30 + 2*i ; index 7 -> 0x3D
  function automatic logic [6:0] strapToAddr(input logic [2:0] idx);
    if (idx == 3'd7) return 7'h3D;
    return 7'h30 + {3'b000, idx, 1'b0};
  endfunction

endpackage

// File: rtl/strap_settle_ctl.sv
module strap_settle_ctl
  import strap_addr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrEnable,
  input  logic        addrValid,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!pwrEnable) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobes.latchStrap = pwrEnable && !ready && (cnt == LAST);
    strobes.decodeEn   = addrValid && ready;
  end

  // R10
  power_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrEnable |=> !ready);

  // R1
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(pwrEnable) && $past(cnt) == LAST));

endmodule

// File: rtl/alias_match_dp.sv
module alias_match_dp
  import strap_addr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 3,
  parameter int PORTS  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic                           addrValid,
  input  logic [IDX_W-1:0]               strapIdx,
  input  logic [ADDR_W:0]                addrByte,
  input  logic [PORTS-1:0][ADDR_W-1:0]   aliasAddr,
  input  logic [PORTS-1:0]               pageCtl,
  output logic                           matchPulse,
  output logic [PORTS-1:0]               pageSel,
  output logic                           pageForced,
  output logic                           rwBit
);
  logic [ADDR_W-1:0] primaryAddr;
  logic [PORTS-1:0]  aliasHit;
  logic [PORTS-1:0]  aliasSel;
  logic [PORTS-1:0]  lowestPage;
  logic              primHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   primaryAddr <= '0;
    else if (strobes.latchStrap) primaryAddr <= strapToAddr(strapIdx);
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_alias
    assign aliasHit[p] = (aliasAddr[p] != '0) && (aliasAddr[p] == addrByte[ADDR_W:1]);
  end

  assign primHit    = (primaryAddr == addrByte[ADDR_W:1]);
  assign lowestPage = pageCtl & (~pageCtl + 1'b1);
  assign aliasSel   = aliasHit & (~aliasHit + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      pageSel    <= '0;
      pageForced <= 1'b0;
      rwBit      <= 1'b0;
    end else begin
      matchPulse <= 1'b0;
      pageSel    <= '0;
      pageForced <= 1'b0;
      if (addrValid) rwBit <= addrByte[0];
      if (strobes.decodeEn) begin
        if (primHit) begin
          matchPulse <= 1'b1;
          pageSel    <= addrByte[0] ? lowestPage : pageCtl;
        end else if (aliasHit != '0) begin
          matchPulse <= 1'b1;
          pageSel    <= aliasSel;
          pageForced <= 1'b1;
        end
      end
    end
  end

  // R9
  match_needs_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(strobes.decodeEn));

  // R6
  forced_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageForced |-> (matchPulse && $countones(pageSel) == 1));

  // R7
  primary_page_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !pageForced) |-> ((pageSel & ~$past(pageCtl)) == '0));

  // R4
  rw_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrValid) |-> (rwBit == $past(addrByte[0])));

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.latchStrap) |-> $stable(primaryAddr));

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
  import strap_addr_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrEnable,
  input  logic [2:0] strapIdx,
  input  logic       addrValid,
  input  logic [7:0] addrByte,
  input  logic [7:0] alias0Reg,
  input  logic [7:0] alias1Reg,
  input  logic [1:0] pageCtl,
  output logic       matchPulse,
  output logic [1:0] pageSel,
  output logic       pageForced,
  output logic       rwBit
);
  localparam int SETTLE_CYCLES = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  ctlStrobes_t      strobes;
  logic [1:0][6:0]  aliasAddr;
  logic             unusedAliasLsb;

  assign aliasAddr      = {alias1Reg[7:1], alias0Reg[7:1]};
  assign unusedAliasLsb = alias0Reg[0] ^ alias1Reg[0];

  strap_settle_ctl #(.SETTLE_CYCLES(SETTLE_CYCLES)) ctl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrEnable (pwrEnable),
    .addrValid (addrValid),
    .strobes   (strobes)
  );

  alias_match_dp #(.ADDR_W(7), .IDX_W(3), .PORTS(2)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addrValid  (addrValid),
    .strapIdx   (strapIdx),
    .addrByte   (addrByte),
    .aliasAddr  (aliasAddr),
    .pageCtl    (pageCtl),
    .matchPulse (matchPulse),
    .pageSel    (pageSel),
    .pageForced (pageForced),
    .rwBit      (rwBit)
  );

endmodule

// File: tb/strap_addr_decoder_test.sv
module strap_addr_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 20000;
  localparam int SETTLE     = CLK_HZ / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrEnable = 1'b0;
  logic [2:0] strapIdx = 3'd0;
  logic       addrValid = 1'b0;
  logic [7:0] addrByte = 8'h00;
  logic [7:0] alias0Reg = 8'h00;
  logic [7:0] alias1Reg = 8'h00;
  logic [1:0] pageCtl = 2'b00;
  logic       matchPulse;
  logic [1:0] pageSel;
  logic       pageForced;
  logic       rwBit;

  int checks = 0;
  int fails  = 0;

  strap_addr_decoder #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .pwrEnable(pwrEnable), .strapIdx(strapIdx),
    .addrValid(addrValid), .addrByte(addrByte), .alias0Reg(alias0Reg),
    .alias1Reg(alias1Reg), .pageCtl(pageCtl), .matchPulse(matchPulse),
    .pageSel(pageSel), .pageForced(pageForced), .rwBit(rwBit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {addrByte, alias0, alias1, pageCtl, expMatch, expSel, expForced}; primary = 0x36
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {8'h6C, 8'h00, 8'h00, 2'b11, 1'b1, 2'b11, 1'b0},  // R7 write
    {8'h6D, 8'h00, 8'h00, 2'b11, 1'b1, 2'b01, 1'b0},  // R7 read lowest
    {8'h6D, 8'h00, 8'h00, 2'b10, 1'b1, 2'b10, 1'b0},  // R7
    {8'h6D, 8'h00, 8'h00, 2'b00, 1'b1, 2'b00, 1'b0},  // R7 empty
    {8'h80, 8'h80, 8'h00, 2'b10, 1'b1, 2'b01, 1'b1},  // R6 alias0
    {8'h81, 8'h81, 8'h00, 2'b10, 1'b1, 2'b01, 1'b1},  // R5 lsb ignored
    {8'h91, 8'h00, 8'h90, 2'b01, 1'b1, 2'b10, 1'b1},  // R6 alias1
    {8'h6C, 8'h6C, 8'h00, 2'b10, 1'b1, 2'b10, 1'b0},  // R8 primary wins
    {8'h90, 8'h90, 8'h90, 2'b10, 1'b1, 2'b01, 1'b1},  // R8 alias0 wins
    {8'h00, 8'h00, 8'h00, 2'b11, 1'b0, 2'b00, 1'b0},  // R5 disabled
    {8'h00, 8'h00, 8'h01, 2'b11, 1'b0, 2'b00, 1'b0},  // R5 zero upper bits
    {8'h6A, 8'h80, 8'h90, 2'b11, 1'b0, 2'b00, 1'b0}   // R9 miss
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one address byte; returns after the edge that registers the result
  task automatic sendAddr(input logic [7:0] b);
    addrByte  = b;
    addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic powerUp(input logic [2:0] idx);
    pwrEnable = 1'b0;
    strapIdx  = idx;
    @(negedge clk);
    pwrEnable = 1'b1;
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 matchPulse", {7'b0, matchPulse}, 8'h0);
    chk("R11 pageSel", {6'b0, pageSel}, 8'h0);
    chk("R11 pageForced/rwBit", {6'b0, pageForced, rwBit}, 8'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2 exact capture edge, strap 3 -> 0x36
    strapIdx  = 3'd3;
    pwrEnable = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    sendAddr(8'h6C);
    chk("R2 nack on capture edge", {7'b0, matchPulse}, 8'h0);
    sendAddr(8'h6C);
    chk("R1 match after capture edge", {7'b0, matchPulse}, 8'h1);

    // R1 strap change ignored after capture
    strapIdx = 3'd5;
    sendAddr(8'h6C);
    chk("R1 old address kept", {7'b0, matchPulse}, 8'h1);
    sendAddr(8'h74);
    chk("R1 new strap ignored", {7'b0, matchPulse}, 8'h0);
    strapIdx = 3'd3;

    // vector table
    for (int i = 0; i < NV; i++) begin
      alias0Reg = VEC[i][21:14];
      alias1Reg = VEC[i][13:6];
      pageCtl   = VEC[i][5:4];
      sendAddr(VEC[i][29:22]);
      chk($sformatf("R7/R6 vec%0d match", i), {7'b0, matchPulse}, {7'b0, VEC[i][3]});
      chk($sformatf("R7/R6 vec%0d pageSel", i), {6'b0, pageSel}, {6'b0, VEC[i][2:1]});
      chk($sformatf("R6 vec%0d forced", i), {7'b0, pageForced}, {7'b0, VEC[i][0]});
      chk($sformatf("R4 vec%0d rw", i), {7'b0, rwBit}, {7'b0, VEC[i][22]});
      @(negedge clk);
      chk($sformatf("R9 vec%0d pulse ends", i), {6'b0, matchPulse, pageForced}, 8'h0);
      chk($sformatf("R4 vec%0d rw held", i), {7'b0, rwBit}, {7'b0, VEC[i][22]});
    end

    // R10 power drop stops matching
    alias0Reg = 8'h80;
    pwrEnable = 1'b0;
    @(negedge clk);
    sendAddr(8'h6C);
    chk("R10 primary nack while down", {7'b0, matchPulse}, 8'h0);
    sendAddr(8'h80);
    chk("R10 alias nack while down", {7'b0, matchPulse}, 8'h0);

    // R3 every strap index through a fresh power-up
    for (int k = 0; k < 8; k++) begin
      logic [6:0] expA;
      expA = (k == 7) ? 7'h3D : 7'(8'h30 + 2 * k);
      powerUp(3'(k));
      sendAddr({expA, 1'b0});
      chk($sformatf("R3 R10 idx%0d match", k), {7'b0, matchPulse}, 8'h1);
      sendAddr({expA + 7'd1, 1'b0});
      chk($sformatf("R3 idx%0d neighbour nack", k), {7'b0, matchPulse}, 8'h0);
    end

    // R2 nack during settle for alias too
    pwrEnable = 1'b0;
    @(negedge clk);
    pwrEnable = 1'b1;
    repeat (2) @(negedge clk);
    sendAddr(8'h80);
    chk("R2 alias nack during settle", {7'b0, matchPulse}, 8'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule